// File: doc/BRIEF.md
# Dual-Channel Indirect Register Interface

This block is the processor-facing register front end of a two-channel serial controller. Each channel offers only two bus locations: a command location and a data location. The sixteen 8-bit write registers and sixteen read registers of each channel are reached through the command location. The first write there loads a register pointer. The next access then writes the register that the pointer names, or a read returns it. After either one, the pointer goes back to zero.

The serial engine sits beside this block and gets three things from it. It reads configuration through a private lookup port. It receives transmit bytes as one-cycle strobes. It offers receive bytes, which a data-location read takes, raising a pop pulse. The engine also raises interrupt-pending bits. These collect in status register 3 of channel A and drive the interrupt line until software reads that register. The block also accepts a legacy word style of access. In this style the byte sits in bits 15:8 of a word written to the offset just below the real location.

Top module: `dual_chan_regif`

## Requirements
- R1: Address bit 3 selects the channel (0 = A, 1 = B). Bits 2:0 give the offset within the channel: offset 1 is the command location and offset 5 is the data location. Write register n of channel c appears on the configuration port at index {c, n[3:0]}, one cycle after that index is applied.
- R2: A command write while no selection is pending loads data bits 3:0 into that channel's pointer and marks a selection pending. No register changes.
- R3: A command write while a selection is pending stores data bits 7:0 into the write register named by the pointer. The pointer then returns to 0 and the pending mark clears.
- R4: A command read places {8'h00, read register[pointer]} on bus_rdata in the cycle after the strobe. The pointer then returns to 0 and the pending mark clears, so the next command write is a pointer load.
- R5: Read registers 12 and 13 of a channel follow that channel's write registers 12 and 13 whenever those are written. Read registers other than 3, 12 and 13 read as zero.
- R6: Bits set on ip_set are ORed into read register 3 of channel A. irq_out is high while that register is nonzero. Read register 3 of channel B always reads zero.
- R7: A command read of read register 3 on channel A returns its value and clears it, so irq_out falls in the next cycle. Bits raised on ip_set in that same cycle survive the clear.
- R8: An access at offset 0 or 4 whose data bits 7:0 are zero acts on offset 1 or 5 respectively, using data bits 15:8. Read data for such an access is returned shifted left by 8 bits.
- R9: A data-location write pulses that channel's bit of tx_strobe for one cycle, with tx_byte holding the byte. A data-location read returns that channel's rx_bytes lane on bus_rdata and pulses its rx_pop bit, both in the cycle after the strobe.
- R10: Accesses at any other offset leave pointer, pending mark and registers untouched, raise no strobe, and read as zero.
- R11: Reset clears all write and read registers, the pointers, the pending marks, bus_rdata and the strobes.
- R12: Data-location accesses leave the pointer and pending mark of both channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address: channel in bit 3, offset in bits 2:0 |
| bus_wr | input | 1 | Write strobe, one cycle per access (takes precedence over bus_rd) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data; bits 7:0 also qualify the shifted style on reads |
| bus_rdata | output | 16 | Registered read data, valid the cycle after bus_rd |
| irq_out | output | 1 | Interrupt request, high while channel A status register 3 is nonzero |
| ip_set | input | 8 | Pending bits from the serial engine, ORed into channel A status register 3 |
| tx_strobe | output | 2 | One-hot per channel: transmit byte available |
| tx_byte | output | 8 | Transmit byte from the last data-location write |
| rx_bytes | input | 16 | Receive byte offered per channel, channel A in bits 7:0 |
| rx_pop | output | 2 | One-hot per channel: receive byte taken |
| cfg_sel | input | 5 | Configuration lookup index {channel, register} |
| cfg_data | output | 8 | Write register contents at cfg_sel, one cycle latency |

## Verification
The hardest states to reach are those where the two-phase protocol is half done. Examples are a pointer loaded and then followed by a data access or a stray offset, or a clear of status register 3 that lands in the same cycle as a new pending bit. Write registers cannot be read back over the bus, so the bench shows the state of the pointer indirectly. After the disturbing access it issues one more command write and looks at the configuration port. If the byte landed in the register named earlier, the selection was still pending. If the byte became a new pointer instead, the selection had been lost. The interrupt collision is driven by raising ip_set in the same cycle as the command read of register 3.

// File: rtl/regif_pkg.sv
package regif_pkg;

  // Offsets inside one channel window
  localparam logic [2:0] OFF_CMD  = 3'd1;
  localparam logic [2:0] OFF_DATA = 3'd5;
  localparam logic [2:0] OFF_LOWA = 3'd0;
  localparam logic [2:0] OFF_LOWB = 3'd4;

  // Register indices with special behaviour
  localparam int unsigned IDX_PENDING = 3;
  localparam int unsigned IDX_MIR_LO  = 12;
  localparam int unsigned IDX_MIR_HI  = 13;

  typedef struct packed {
    logic cmd_wr;
    logic cmd_rd;
    logic dat_wr;
    logic dat_rd;
    logic shifted;
  } acc_t;

endpackage

// File: rtl/regif_decode.sv
module regif_decode
  import regif_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned REG_W = 8,
  parameter int unsigned CH_W  = 1,
  localparam int unsigned ADDR_W = CH_W + 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CH_W-1:0]   ch,
  output acc_t              acc,
  output logic [REG_W-1:0]  wbyte
);

  logic [2:0] off_raw;
  logic [2:0] off_eff;
  logic       rd_only;
  logic       low_zero;

  always_comb begin
    off_raw  = addr[2:0];
    ch       = addr[ADDR_W-1:3];
    rd_only  = rd && !wr;
    low_zero = (wdata[REG_W-1:0] == '0);

    acc.shifted = (wr || rd_only) && low_zero &&
                  ((off_raw == OFF_LOWA) || (off_raw == OFF_LOWB));
    off_eff     = acc.shifted ? (off_raw + 3'd1) : off_raw;
    wbyte       = acc.shifted ? wdata[2*REG_W-1:REG_W] : wdata[REG_W-1:0];

    acc.cmd_wr  = wr      && (off_eff == OFF_CMD);
    acc.cmd_rd  = rd_only && (off_eff == OFF_CMD);
    acc.dat_wr  = wr      && (off_eff == OFF_DATA);
    acc.dat_rd  = rd_only && (off_eff == OFF_DATA);
  end

endmodule

// File: rtl/regif_chan.sv
module regif_chan
  import regif_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned NREG   = 16,
  parameter bit          HAS_IP = 1'b1,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_rd,
  input  logic [REG_W-1:0] wbyte,
  input  logic [REG_W-1:0] ip_set,
  input  logic [IDX_W-1:0] cfg_idx,
  output logic [REG_W-1:0] rd_byte,
  output logic             irq_any,
  output logic [IDX_W-1:0] ptr,
  output logic             pend,
  output logic [REG_W-1:0] cfg_q
);

  localparam logic [IDX_W-1:0] P_IDX  = IDX_W'(IDX_PENDING);
  localparam logic [IDX_W-1:0] M_LO   = IDX_W'(IDX_MIR_LO);
  localparam logic [IDX_W-1:0] M_HI   = IDX_W'(IDX_MIR_HI);

  logic [REG_W-1:0] wbank [NREG];
  logic [REG_W-1:0] rr_mlo;
  logic [REG_W-1:0] rr_mhi;
  logic [REG_W-1:0] rr_ip;

  // Pointer protocol, write bank and mirrored read registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      pend   <= 1'b0;
      rr_mlo <= '0;
      rr_mhi <= '0;
      cfg_q  <= '0;
      for (int i = 0; i < NREG; i++) wbank[i] <= '0;
    end else begin
      cfg_q <= wbank[cfg_idx];
      if (cmd_wr) begin
        if (!pend) begin
          ptr  <= wbyte[IDX_W-1:0];
          pend <= 1'b1;
        end else begin
          wbank[ptr] <= wbyte;
          if (ptr == M_LO) rr_mlo <= wbyte;
          if (ptr == M_HI) rr_mhi <= wbyte;
          ptr  <= '0;
          pend <= 1'b0;
        end
      end else if (cmd_rd) begin
        ptr  <= '0;
        pend <= 1'b0;
      end
    end
  end

  // Pending-interrupt status register, only on the channel that owns it
  generate
    if (HAS_IP) begin : g_ip
      logic clr_now;
      assign clr_now = cmd_rd && (ptr == P_IDX);
      always_ff @(posedge clk) begin
        if (rst) rr_ip <= '0;
        else     rr_ip <= (clr_now ? '0 : rr_ip) | ip_set;
      end
    end else begin : g_no_ip
      logic [REG_W-1:0] ip_unused;
      assign ip_unused = ip_set;
      always_ff @(posedge clk) rr_ip <= '0;
    end
  endgenerate

  assign irq_any = |rr_ip;

  always_comb begin
    unique case (ptr)
      P_IDX:   rd_byte = rr_ip;
      M_LO:    rd_byte = rr_mlo;
      M_HI:    rd_byte = rr_mhi;
      default: rd_byte = '0;
    endcase
  end

endmodule

// File: rtl/dual_chan_regif.sv
module dual_chan_regif
  import regif_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned NREG   = 16,
  parameter int unsigned BUS_W  = 16,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned ADDR_W = CH_W + 3,
  localparam int unsigned SEL_W  = CH_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic                    irq_out,
  input  logic [REG_W-1:0]        ip_set,
  output logic [NUM_CH-1:0]       tx_strobe,
  output logic [REG_W-1:0]        tx_byte,
  input  logic [NUM_CH*REG_W-1:0] rx_bytes,
  output logic [NUM_CH-1:0]       rx_pop,
  input  logic [SEL_W-1:0]        cfg_sel,
  output logic [REG_W-1:0]        cfg_data
);

  logic [CH_W-1:0]  dec_ch;
  acc_t             dec_acc;
  logic [REG_W-1:0] dec_byte;

  regif_decode #(
    .BUS_W (BUS_W),
    .REG_W (REG_W),
    .CH_W  (CH_W)
  ) u_decode (
    .addr  (bus_addr),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .wdata (bus_wdata),
    .ch    (dec_ch),
    .acc   (dec_acc),
    .wbyte (dec_byte)
  );

  logic [REG_W-1:0]        rd_byte_v [NUM_CH];
  logic [REG_W-1:0]        cfg_q_v   [NUM_CH];
  logic [NUM_CH-1:0]       irq_v;
  logic [NUM_CH-1:0]       pend_vec;
  logic [NUM_CH*IDX_W-1:0] ptr_flat;
  logic [NUM_CH-1:0]       ch_hit;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [IDX_W-1:0] ptr_c;
      assign ch_hit[c] = (dec_ch == CH_W'(c));
      regif_chan #(
        .REG_W  (REG_W),
        .NREG   (NREG),
        .HAS_IP (c == 0)
      ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (dec_acc.cmd_wr && ch_hit[c]),
        .cmd_rd  (dec_acc.cmd_rd && ch_hit[c]),
        .wbyte   (dec_byte),
        .ip_set  ((c == 0) ? ip_set : '0),
        .cfg_idx (cfg_sel[IDX_W-1:0]),
        .rd_byte (rd_byte_v[c]),
        .irq_any (irq_v[c]),
        .ptr     (ptr_c),
        .pend    (pend_vec[c]),
        .cfg_q   (cfg_q_v[c])
      );
      assign ptr_flat[c*IDX_W +: IDX_W] = ptr_c;
    end
  endgenerate

  assign irq_out = |irq_v;

  // Read value before the legacy shift
  logic [REG_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (dec_acc.cmd_rd)      rd_val = rd_byte_v[dec_ch];
    else if (dec_acc.dat_rd) rd_val = rx_bytes[dec_ch*REG_W +: REG_W];
  end

  logic [CH_W-1:0] cfg_ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_strobe <= '0;
      tx_byte   <= '0;
      rx_pop    <= '0;
      cfg_ch_q  <= '0;
    end else begin
      cfg_ch_q  <= cfg_sel[SEL_W-1:IDX_W];
      tx_strobe <= dec_acc.dat_wr ? ch_hit : '0;
      rx_pop    <= dec_acc.dat_rd ? ch_hit : '0;
      if (dec_acc.dat_wr) tx_byte <= dec_byte;
      if (bus_rd && !bus_wr) begin
        if (dec_acc.shifted) bus_rdata <= BUS_W'(rd_val) << REG_W;
        else                 bus_rdata <= BUS_W'(rd_val);
      end
    end
  end

  assign cfg_data = cfg_q_v[cfg_ch_q];

endmodule

// File: rtl/regif_checker.sv
module regif_checker #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned CH_W   = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [CH_W-1:0]         dec_ch,
  input logic                    cmd_wr,
  input logic                    cmd_rd,
  input logic                    dat_wr,
  input logic                    dat_rd,
  input logic [NUM_CH-1:0]       pend_vec,
  input logic [NUM_CH*IDX_W-1:0] ptr_flat,
  input logic [REG_W-1:0]        ip_set,
  input logic                    irq_out,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [NUM_CH-1:0]       tx_strobe,
  input logic [NUM_CH-1:0]       rx_pop
);

  // R2: pointer load on channel A marks a selection pending
  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && dec_ch == '0 && !pend_vec[0]) |=> pend_vec[0]);

  // R3: second command write ends the selection
  assert_sel_done_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && dec_ch == '0 && pend_vec[0]) |=>
      (!pend_vec[0] && ptr_flat[IDX_W-1:0] == '0));

  // R4: a command read returns the pointer to zero
  assert_ptr_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && dec_ch == '0) |=> (!pend_vec[0] && ptr_flat[IDX_W-1:0] == '0));

  // R6: any pending bit raises the interrupt
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (ip_set != '0) |=> irq_out);

  // R7: reading status register 3 with nothing new arriving drops the line
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && dec_ch == '0 && ptr_flat[IDX_W-1:0] == IDX_W'(3) && ip_set == '0)
      |=> !irq_out);

  // R9: strobes are single, one-hot and caused by a bus access
  assert_tx_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_strobe != '0) |-> ($past(bus_wr) && $onehot0(tx_strobe)));
  assert_rx_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_pop != '0) |-> ($past(bus_rd) && $onehot0(rx_pop)));

  // R12: data accesses leave the pointer state alone
  assert_ptr_keep_R12: assert property (@(posedge clk) disable iff (rst)
    (dat_wr || dat_rd) |=> ($stable(pend_vec) && $stable(ptr_flat)));

endmodule

bind dual_chan_regif regif_checker #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W),
  .REG_W  (REG_W),
  .CH_W   (CH_W)
) u_regif_checker (
  .clk       (clk),
  .rst       (rst),
  .dec_ch    (dec_ch),
  .cmd_wr    (dec_acc.cmd_wr),
  .cmd_rd    (dec_acc.cmd_rd),
  .dat_wr    (dec_acc.dat_wr),
  .dat_rd    (dec_acc.dat_rd),
  .pend_vec  (pend_vec),
  .ptr_flat  (ptr_flat),
  .ip_set    (ip_set),
  .irq_out   (irq_out),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .tx_strobe (tx_strobe),
  .rx_pop    (rx_pop)
);

// File: tb/test_dual_chan_regif.sv
module test_dual_chan_regif;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_out;
  logic [7:0]  ip_set;
  logic [1:0]  tx_strobe;
  logic [7:0]  tx_byte;
  logic [15:0] rx_bytes;
  logic [1:0]  rx_pop;
  logic [4:0]  cfg_sel;
  logic [7:0]  cfg_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dual_chan_regif i_dual_chan_regif (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .ip_set(ip_set), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte), .rx_bytes(rx_bytes), .rx_pop(rx_pop),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; results sampled at the following negedge
  task automatic bus_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0; bus_wdata = '0;
    q = bus_rdata;
  endtask

  task automatic cfg_read(logic [4:0] idx, output logic [7:0] q);
    @(negedge clk);
    cfg_sel = idx;
    @(negedge clk);
    q = cfg_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] q;
    int bad = 0;
    check("R11 rdata", bus_rdata, 16'h0);
    check("R11 irq", {15'h0, irq_out}, 16'h0);
    check("R11 tx", {14'h0, tx_strobe}, 16'h0);
    for (int i = 0; i < 32; i++) begin
      cfg_read(5'(i), q);
      if (q !== 8'h0) bad++;
    end
    check("R11 write bank clear count", 16'(bad), 16'h0);
  endtask

  task automatic t_pointer_write();
    logic [7:0] q;
    bus_write(4'd1, 16'h0005);      // R2 pointer load, channel A
    cfg_read(5'd5, q);
    check("R2 pointer load stores nothing", {8'h0, q}, 16'h0);
    bus_write(4'd1, 16'h00A5);      // R3 data phase
    cfg_read(5'd5, q);
    check("R3 WR5 channel A", {8'h0, q}, 16'h00A5);
    bus_write(4'd9, 16'h0007);      // channel B
    bus_write(4'd9, 16'h003C);
    cfg_read(5'd23, q);
    check("R1 WR7 channel B", {8'h0, q}, 16'h003C);
    cfg_read(5'd7, q);
    check("R1 WR7 channel A untouched", {8'h0, q}, 16'h0);
  endtask

  task automatic t_read_and_mirror();
    logic [15:0] r;
    logic [7:0]  q;
    bus_write(4'd1, 16'h000C);
    bus_write(4'd1, 16'h005A);
    bus_write(4'd1, 16'h000C);
    bus_read(4'd1, 16'h0, r);
    check("R5 RR12 mirrors WR12", r, 16'h005A);
    bus_write(4'd1, 16'h000D);       // must be a pointer load after R4 read
    bus_write(4'd1, 16'h0077);
    cfg_read(5'd13, q);
    check("R4 pointer cleared by read", {8'h0, q}, 16'h0077);
    bus_write(4'd1, 16'h000D);
    bus_read(4'd1, 16'h0, r);
    check("R5 RR13 mirrors WR13", r, 16'h0077);
    bus_write(4'd1, 16'h0005);
    bus_read(4'd1, 16'h0, r);
    check("R5 RR5 reads zero", r, 16'h0);
    bus_read(4'd1, 16'h0, r);
    check("R4 read without load gives RR0", r, 16'h0);
  endtask

  task automatic t_interrupt();
    logic [15:0] r;
    @(negedge clk); ip_set = 8'h24;
    @(negedge clk); ip_set = 8'h00;
    check("R6 irq raised", {15'h0, irq_out}, 16'h1);
    bus_write(4'd9, 16'h0003);
    bus_read(4'd9, 16'h0, r);
    check("R6 channel B RR3 zero", r, 16'h0);
    check("R6 irq kept after B read", {15'h0, irq_out}, 16'h1);
    bus_write(4'd1, 16'h0003);
    bus_read(4'd1, 16'h0, r);
    check("R7 RR3 value", r, 16'h0024);
    check("R7 irq cleared", {15'h0, irq_out}, 16'h0);
    // collision: new bit in the same cycle as the clearing read
    @(negedge clk); ip_set = 8'h01;
    @(negedge clk); ip_set = 8'h00;
    bus_write(4'd1, 16'h0003);
    @(negedge clk);
    bus_addr = 4'd1; bus_wdata = 16'h0; bus_rd = 1'b1; ip_set = 8'h80;
    @(negedge clk);
    bus_rd = 1'b0; ip_set = 8'h00;
    check("R7 collision read value", bus_rdata, 16'h0001);
    check("R7 new bit survives clear", {15'h0, irq_out}, 16'h1);
    bus_write(4'd1, 16'h0003);
    bus_read(4'd1, 16'h0, r);
    check("R7 surviving value", r, 16'h0080);
  endtask

  task automatic t_shifted();
    logic [15:0] r;
    logic [7:0]  q;
    bus_write(4'd0, 16'h0300);       // pointer 3 via legacy style
    bus_write(4'd0, 16'h4100);
    cfg_read(5'd3, q);
    check("R8 shifted write WR3", {8'h0, q}, 16'h0041);
    bus_write(4'd0, 16'h0D00);
    bus_read(4'd0, 16'h0000, r);
    check("R8 shifted read RR13", r, 16'h7700);
    @(negedge clk);
    bus_addr = 4'd4; bus_wdata = 16'h5500; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 shifted data write strobe", {14'h0, tx_strobe}, 16'h1);
    check("R8 shifted data byte", {8'h0, tx_byte}, 16'h0055);
  endtask

  task automatic t_data_path();
    logic [15:0] r;
    @(negedge clk);
    bus_addr = 4'd13; bus_wdata = 16'h0061; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 tx strobe channel B", {14'h0, tx_strobe}, 16'h2);
    check("R9 tx byte", {8'h0, tx_byte}, 16'h0061);
    @(negedge clk);
    check("R9 tx strobe one cycle", {14'h0, tx_strobe}, 16'h0);
    rx_bytes = 16'h9E11;
    @(negedge clk);
    bus_addr = 4'd13; bus_wdata = 16'h0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R9 rx data channel B", bus_rdata, 16'h009E);
    check("R9 rx pop channel B", {14'h0, rx_pop}, 16'h2);
    bus_read(4'd5, 16'h0, r);
    check("R9 rx data channel A", r, 16'h0011);
  endtask

  task automatic t_pending_kept();
    logic [7:0] q;
    bus_write(4'd1, 16'h000C);       // load pointer
    bus_write(4'd5, 16'h0042);       // data write in between
    bus_write(4'd1, 16'h0011);       // must land in WR12
    cfg_read(5'd12, q);
    check("R12 pending survives data access", {8'h0, q}, 16'h0011);
  endtask

  task automatic t_other_offsets();
    logic [15:0] r;
    logic [7:0]  q;
    @(negedge clk);
    bus_addr = 4'd2; bus_wdata = 16'h0005; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 no strobe on offset 2", {14'h0, tx_strobe}, 16'h0);
    bus_write(4'd1, 16'h000E);       // still a pointer load
    bus_write(4'd1, 16'h0022);
    cfg_read(5'd14, q);
    check("R10 offset 2 write ignored", {8'h0, q}, 16'h0022);
    bus_read(4'd3, 16'h0, r);
    check("R10 offset 3 reads zero", r, 16'h0);
    bus_read(4'd0, 16'h0001, r);
    check("R10 offset 0 non-shifted reads zero", r, 16'h0);
  endtask

  task automatic t_mid_reset();
    logic [7:0] q;
    bus_write(4'd1, 16'h0005);       // leave a selection pending
    do_reset();
    cfg_read(5'd5, q);
    check("R11 WR5 cleared", {8'h0, q}, 16'h0);
    bus_write(4'd1, 16'h0006);
    bus_write(4'd1, 16'h0033);
    cfg_read(5'd6, q);
    check("R11 pending cleared", {8'h0, q}, 16'h0033);
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; ip_set = '0; rx_bytes = '0; cfg_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_pointer_write();
    t_read_and_mirror();
    t_interrupt();
    t_shifted();
    t_data_path();
    t_pending_kept();
    t_other_offsets();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule